// File: doc/BRIEF.md
# Level-Masked Interrupt Priority Controller

This block gathers interrupt requests from a fixed set of sources for a small CPU. Each source owns a pending flag, which only hardware can set, and a 3-bit priority level that software writes. A request is put to the CPU only when three things hold together: the global enable is on, the source is pending, and its level is strictly above the CPU's current priority level.

When several sources are eligible, the block picks the one with the highest level. A tie goes to the lower index. The winner's index and level are presented on registered outputs and held steady until the CPU acknowledges. The acknowledge clears the winner's pending flag.

Software has one write port. With it, software can set a source's level or cancel a pending request. A combinational read port returns the pending flag and the level of any source.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, every pending flag is 0, every level is 0 and `irq_o` is 0.
- R2: `irq_o` rises only when `gie_i` is 1, the source is pending, and its level is greater than `cpu_ipl_i`. A pulse sampled at clock edge k sets the flag at edge k. The request then appears after edge k+1.
- R3: A level of 0 never presents its source. A `cpu_ipl_i` of 7 blocks every source. In general, a `cpu_ipl_i` of n admits only levels n+1 and above.
- R4: Among eligible sources, the highest level wins. Ties go to the lowest source index.
- R5: A one-cycle pulse on `src_req_i[i]` sets pending flag i.
- R6: If `ack_i` is sampled high while `irq_o` is 1, the presented source's pending flag is cleared and `irq_o` is 0 after that edge.
- R7: A write with `wr_en_i`=1 and `wr_sel_i`=1 targets the pending flag of source `wr_idx_i`. If `wr_data_i[0]`=0 the flag is cleared. If `wr_data_i[0]`=1 the write has no effect.
- R8: If a hardware pulse and a software clear hit the same flag in the same cycle, the flag ends up set.
- R9: While `irq_o` is 1 and no acknowledge is sampled, `irq_idx_o` and `irq_lvl_o` stay constant. This holds even if a higher-level source becomes pending.
- R10: A pending source whose level is at or below `cpu_ipl_i` stays pending but is not presented. It is presented again once its level is raised above `cpu_ipl_i`.
- R11: A write with `wr_sel_i`=0 sets the level of source `wr_idx_i` to `wr_data_i`. Writing a level does not change any pending flag, and clearing a pending flag does not change any level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req_i | input | NSRC | Single-cycle request pulses, one per source |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | 0 selects a level write, 1 selects a pending-flag write |
| wr_idx_i | input | IDXW | Source addressed by the write |
| wr_data_i | input | LVLW | Level value, or bit 0 as the pending value |
| rd_idx_i | input | IDXW | Source addressed by the read port |
| rd_pend_o | output | 1 | Pending flag of the addressed source |
| rd_lvl_o | output | LVLW | Level of the addressed source |
| gie_i | input | 1 | Global maskable-interrupt enable |
| cpu_ipl_i | input | LVLW | Current processor priority level |
| ack_i | input | 1 | CPU acknowledge of the presented request |
| irq_o | output | 1 | Interrupt request to the CPU |
| irq_idx_o | output | IDXW | Index of the presented source |
| irq_lvl_o | output | LVLW | Level of the presented source |

## Verification
The hardest situation to reach is a source that is pending but kept silent. This happens when its level is lowered to or below the processor level, or when it collides with a software clear in the same cycle. Neither case leaves a trace on `irq_o`. To reach them, the stimulus holds the global enable low or raises the processor level while it pulses the source and rewrites the level. It then reads the hidden flag back through the read port. Finally it re-opens the mask and expects the source to be presented with its new level.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int NSRC = 8,
  parameter int LVLW = 3,
  localparam int IDXW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_req_i,
  input  logic            wr_en_i,
  input  logic            wr_sel_i,
  input  logic [IDXW-1:0] wr_idx_i,
  input  logic [LVLW-1:0] wr_data_i,
  input  logic [IDXW-1:0] rd_idx_i,
  output logic            rd_pend_o,
  output logic [LVLW-1:0] rd_lvl_o,
  input  logic            gie_i,
  input  logic [LVLW-1:0] cpu_ipl_i,
  input  logic            ack_i,
  output logic            irq_o,
  output logic [IDXW-1:0] irq_idx_o,
  output logic [LVLW-1:0] irq_lvl_o
);

  logic [NSRC-1:0] pend;
  logic [LVLW-1:0] lvl [NSRC];
  logic [NSRC-1:0] sw_clr, ack_clr;
  logic            found;
  logic [IDXW-1:0] best_idx;
  logic [LVLW-1:0] best_lvl;

  assign sw_clr  = (wr_en_i && wr_sel_i && !wr_data_i[0]) ? (NSRC'(1) << wr_idx_i) : '0;
  assign ack_clr = (irq_o && ack_i) ? (NSRC'(1) << irq_idx_o) : '0;

  assign rd_pend_o = pend[rd_idx_i];
  assign rd_lvl_o  = lvl[rd_idx_i];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else        pend <= src_req_i | (pend & ~sw_clr & ~ack_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSRC; i++) lvl[i] <= '0;
    end else if (wr_en_i && !wr_sel_i) begin
      lvl[wr_idx_i] <= wr_data_i;
    end
  end

  always_comb begin
    found    = 1'b0;
    best_idx = '0;
    best_lvl = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (gie_i && pend[i] && lvl[i] > cpu_ipl_i && lvl[i] > best_lvl) begin
        found    = 1'b1;
        best_idx = IDXW'(i);
        best_lvl = lvl[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_o     <= 1'b0;
      irq_idx_o <= '0;
      irq_lvl_o <= '0;
    end else if (irq_o) begin
      if (ack_i) irq_o <= 1'b0;
    end else if (found) begin
      irq_o     <= 1'b1;
      irq_idx_o <= best_idx;
      irq_lvl_o <= best_lvl;
    end
  end

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o && !ack_i |=> irq_o && $stable(irq_idx_o) && $stable(irq_lvl_o));

  p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o && ack_i && src_req_i == '0 |=> !irq_o && !pend[$past(irq_idx_o)]);

  p_eligible_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(gie_i) && ($past(cpu_ipl_i) < irq_lvl_o));

  p_level_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> irq_lvl_o != '0);

  p_hw_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    src_req_i != '0 |=> (pend & $past(src_req_i)) == $past(src_req_i));

  p_sw_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i && wr_sel_i && wr_data_i[0] && src_req_i == '0 && !(irq_o && ack_i)
    |=> pend == $past(pend));

endmodule

// File: tb/tb_prio_irq_ctrl.sv
module tb_prio_irq_ctrl;
  localparam int NSRC = 8;
  localparam int LVLW = 3;
  localparam int IDXW = 3;

  logic            clk = 0;
  logic            rst_n = 0;
  logic [NSRC-1:0] src_req_i = '0;
  logic            wr_en_i = 0, wr_sel_i = 0;
  logic [IDXW-1:0] wr_idx_i = '0, rd_idx_i = '0;
  logic [LVLW-1:0] wr_data_i = '0, cpu_ipl_i = '0;
  logic            gie_i = 0, ack_i = 0;
  logic            rd_pend_o, irq_o;
  logic [LVLW-1:0] rd_lvl_o, irq_lvl_o;
  logic [IDXW-1:0] irq_idx_o;

  int checks = 0, errors = 0;
  logic [IDXW+LVLW-1:0] exp_q[$];
  bit done = 0;

  always #4 clk = ~clk;

  prio_irq_ctrl #(.NSRC(NSRC), .LVLW(LVLW)) dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic wr_lvl(input int i, input int l);
    wr_en_i = 1; wr_sel_i = 0; wr_idx_i = IDXW'(i); wr_data_i = LVLW'(l);
    tick();
    wr_en_i = 0;
  endtask

  task automatic wr_pend(input int i, input int b);
    wr_en_i = 1; wr_sel_i = 1; wr_idx_i = IDXW'(i); wr_data_i = LVLW'(b);
    tick();
    wr_en_i = 0;
  endtask

  task automatic pulse(input logic [NSRC-1:0] m);
    src_req_i = m;
    tick();
    src_req_i = '0;
  endtask

  task automatic do_ack();
    ack_i = 1;
    tick();
    ack_i = 0;
  endtask

  task automatic rd_pend(input int i, output bit p, output int l);
    rd_idx_i = IDXW'(i);
    #1;
    p = rd_pend_o;
    l = int'(rd_lvl_o);
  endtask

  task automatic expect_irq(input int i, input int l);
    exp_q.push_back({IDXW'(i), LVLW'(l)});
  endtask

  // monitor: pop on each new presentation
  logic prev_irq = 0;
  always @(posedge clk) begin
    #2;
    if (rst_n && irq_o && !prev_irq) begin
      if (exp_q.size() == 0) begin
        chk(0, "R4 unexpected request", int'(irq_idx_o), -1);
      end else begin
        logic [IDXW+LVLW-1:0] e;
        e = exp_q.pop_front();
        chk(irq_idx_o == e[IDXW+LVLW-1:LVLW], "R4 index", int'(irq_idx_o), int'(e[IDXW+LVLW-1:LVLW]));
        chk(irq_lvl_o == e[LVLW-1:0], "R2 level", int'(irq_lvl_o), int'(e[LVLW-1:0]));
      end
    end
    prev_irq = irq_o;
  end

  initial begin
    for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
    if (!done) begin
      chk(0, "watchdog", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit p; int l;
    tick(2);
    rst_n = 1;
    tick();
    // R1
    chk(irq_o == 0, "R1 irq", irq_o, 0);
    for (int i = 0; i < NSRC; i++) begin
      rd_pend(i, p, l);
      chk(p == 0 && l == 0, "R1 flags", int'(p) * 8 + l, 0);
    end
    gie_i = 1; cpu_ipl_i = 0;

    // R5, R2, R6
    wr_lvl(3, 5);
    pulse(8'h08);
    rd_pend(3, p, l);
    chk(p == 1, "R5 set", p, 1);
    chk(irq_o == 0, "R2 latency", irq_o, 0);
    expect_irq(3, 5);
    tick();
    chk(irq_o == 1, "R2 asserted", irq_o, 1);
    do_ack();
    chk(irq_o == 0, "R6 drop", irq_o, 0);
    rd_pend(3, p, l);
    chk(p == 0, "R6 cleared", p, 0);

    // R9 hold, R4 priority and tie
    wr_lvl(1, 4); wr_lvl(6, 4); wr_lvl(2, 6);
    expect_irq(1, 4);
    pulse(8'h02);
    tick();
    pulse(8'h04);
    tick(3);
    chk(irq_o == 1 && irq_idx_o == 1, "R9 hold", int'(irq_idx_o), 1);
    expect_irq(2, 6);
    do_ack();
    tick();
    chk(irq_idx_o == 2, "R4 highest", int'(irq_idx_o), 2);
    do_ack();
    expect_irq(1, 4); expect_irq(6, 4);
    pulse(8'h42);
    tick();
    chk(irq_idx_o == 1, "R4 tie", int'(irq_idx_o), 1);
    do_ack();
    tick();
    chk(irq_idx_o == 6, "R4 second", int'(irq_idx_o), 6);
    do_ack();
    tick();
    chk(irq_o == 0, "R6 idle", irq_o, 0);

    // R3 level 0 and ipl 7
    pulse(8'h01);
    tick(3);
    chk(irq_o == 0, "R3 level0", irq_o, 0);
    rd_pend(0, p, l);
    chk(p == 1, "R3 pending kept", p, 1);
    wr_pend(0, 0);
    wr_lvl(5, 7);
    cpu_ipl_i = 7;
    pulse(8'h20);
    tick(3);
    chk(irq_o == 0, "R3 ipl7 blocks", irq_o, 0);
    expect_irq(5, 7);
    cpu_ipl_i = 6;
    tick(2);
    chk(irq_o == 1, "R3 ipl6 admits 7", irq_o, 1);
    do_ack();
    cpu_ipl_i = 0;

    // R2 global enable
    gie_i = 0;
    wr_lvl(4, 3);
    pulse(8'h10);
    tick(3);
    chk(irq_o == 0, "R2 gie off", irq_o, 0);
    expect_irq(4, 3);
    gie_i = 1;
    tick(2);
    chk(irq_o == 1, "R2 gie on", irq_o, 1);
    do_ack();

    // R7, R11
    gie_i = 0;
    pulse(8'h04);
    wr_pend(2, 1);
    rd_pend(2, p, l);
    chk(p == 1, "R7 write one ignored", p, 1);
    wr_lvl(2, 3);
    rd_pend(2, p, l);
    chk(p == 1, "R11 level write keeps pending", p, 1);
    wr_pend(2, 0);
    rd_pend(2, p, l);
    chk(p == 0, "R7 write zero clears", p, 0);
    chk(l == 3, "R11 clear keeps level", l, 3);

    // R8 set beats clear
    src_req_i = 8'h04;
    wr_en_i = 1; wr_sel_i = 1; wr_idx_i = 2; wr_data_i = 0;
    tick();
    src_req_i = '0; wr_en_i = 0;
    rd_pend(2, p, l);
    chk(p == 1, "R8 set wins", p, 1);
    wr_pend(2, 0);

    // R10 lowered then raised
    gie_i = 1; cpu_ipl_i = 3;
    wr_lvl(7, 2);
    pulse(8'h80);
    tick(3);
    chk(irq_o == 0, "R10 below ipl", irq_o, 0);
    expect_irq(7, 5);
    wr_lvl(7, 5);
    tick();
    chk(irq_o == 1 && irq_idx_o == 7, "R10 raised", int'(irq_idx_o), 7);
    do_ack();
    gie_i = 0; cpu_ipl_i = 0;
    pulse(8'h80);
    wr_lvl(7, 1);
    cpu_ipl_i = 2; gie_i = 1;
    tick(3);
    chk(irq_o == 0, "R10 lowered", irq_o, 0);
    rd_pend(7, p, l);
    chk(p == 1, "R10 still pending", p, 1);
    expect_irq(7, 1);
    cpu_ipl_i = 0;
    tick(2);
    chk(irq_o == 1 && irq_lvl_o == 1, "R10 re-presented", int'(irq_lvl_o), 1);
    do_ack();
    tick(2);

    chk(exp_q.size() == 0, "R4 scoreboard drained", exp_q.size(), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule